// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns the full-width product. A one-cycle request captures both operands. The block then retires one multiplier bit per clock. Each step looks at the current low bit of the working register and at the bit that was shifted out of it on the previous step. If that pair marks the lower end of a run of ones, the step subtracts the multiplicand. If it marks the first zero above a run, the step adds the multiplicand. Inside a run, or inside a stretch of zeros, the step does no arithmetic. Every step then shifts the whole working register right by one place, keeping the sign.

The working register joins an upper half, one bit wider than the operands, with a lower half that starts out holding the multiplier. Because of the extra bit, the most negative operand can be negated and accumulated without wrapping. When the last step is done, the upper and lower halves hold the product, which is presented as two words. A single-cycle completion pulse marks the result.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, busy_o and done_o are 0 and both product words are 0.
- R2: The output {prod_hi_o, prod_lo_o} equals the signed product of mcand_i and mplier_i, read as two's-complement W-bit values, as a 2W-bit two's-complement value. prod_hi_o holds the upper W bits.
- R3: A request is accepted on a rising edge where start_i is 1 and busy_o is 0. done_o is 1 for exactly one cycle, following the W-th rising edge after the accepting edge.
- R4: busy_o is 1 from the edge after acceptance up to the edge that raises done_o, and 0 while done_o is 1. A start_i pulse while busy_o is 1 is ignored: the result and its timing belong to the first request.
- R5: Extreme operands give the exact result. This covers the most negative value times itself (2^(2W-2)), the most negative value times -1, and the most positive value times the most negative value.
- R6: While busy_o is 0 and no request is accepted, both product words keep their values.
- R7: A zero multiplicand or a zero multiplier gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; sampled when idle |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse: product is valid |
| prod_hi_o | output | W | Upper half of the product |
| prod_lo_o | output | W | Lower half of the product |

## Verification
A 5-bit instance is swept over every pair of operands. That covers every mix of signs, every pattern of runs, alternating bits that force an add or subtract on each step, and operands that end in a run reaching the sign bit. In that last case the pending correction must come from sign extension. A 32-bit instance is driven with the extreme values and with zero operands. These show the widened accumulator at the most negative value, where a W-bit accumulator would wrap. At the same width, a second request is sent in the middle of a running multiplication, and the outputs are watched while idle. Together these separate a correct design from one that restarts or corrupts its result, and from one that drifts while holding.

// File: rtl/booth_pkg.sv
package booth_pkg;
   typedef enum logic [1:0] {
      BOP_SKIP = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;
endpackage

// File: rtl/booth_pair_dec.sv
module booth_pair_dec
   import booth_pkg::*;
(
   input  logic      cur_i,
   input  logic      prev_i,
   output booth_op_e op_o
);
   always_comb begin
      unique case ({cur_i, prev_i})
         2'b10:   op_o = BOP_SUB;   // lower end of a run of ones
         2'b01:   op_o = BOP_ADD;   // first zero above a run
         default: op_o = BOP_SKIP;  // inside a run or inside zeros
      endcase
   end
endmodule

// File: rtl/booth_step.sv
module booth_step
   import booth_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W:0]   acc_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] mcand_i,
   input  booth_op_e    op_i,
   output logic [W:0]   acc_o,
   output logic [W-1:0] lo_o
);
   logic [W:0] mext;
   logic [W:0] sum;

   assign mext = {mcand_i[W-1], mcand_i};

   always_comb begin
      unique case (op_i)
         BOP_ADD: sum = acc_i + mext;
         BOP_SUB: sum = acc_i + (~mext + 1'b1);
         default: sum = acc_i;
      endcase
   end

   // arithmetic right shift of the joined register {sum, lo}
   assign acc_o = {sum[W], sum[W:1]};
   assign lo_o  = {sum[0], lo_i[W-1:1]};
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic load_o,
   output logic last_o
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt_q;

   assign load_o = start_i && !busy_o;
   assign last_o = busy_o && (cnt_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (load_o) begin
         busy_o <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_o) begin
         cnt_q <= cnt_q + 1'b1;
         if (last_o) busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] prod_hi_o,
   output logic [W-1:0] prod_lo_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("booth_seq_mul: W must be at least 2");
      end
   endgenerate

   logic         load, last;
   logic [W:0]   acc_q, acc_n;
   logic [W-1:0] lo_q, lo_n, mcand_q;
   logic         prev_q;
   booth_op_e    op;

   booth_seq_ctrl #(.W(W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .busy_o  (busy_o),
      .load_o  (load),
      .last_o  (last)
   );

   booth_pair_dec u_dec (
      .cur_i  (lo_q[0]),
      .prev_i (prev_q),
      .op_o   (op)
   );

   booth_step #(.W(W)) u_step (
      .acc_i   (acc_q),
      .lo_i    (lo_q),
      .mcand_i (mcand_q),
      .op_i    (op),
      .acc_o   (acc_n),
      .lo_o    (lo_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         lo_q    <= '0;
         mcand_q <= '0;
         prev_q  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= last;
         if (load) begin
            acc_q   <= '0;
            lo_q    <= mplier_i;
            mcand_q <= mcand_i;
            prev_q  <= 1'b0;
         end else if (busy_o) begin
            acc_q  <= acc_n;
            lo_q   <= lo_n;
            prev_q <= lo_q[0];
         end
      end
   end

   assign prod_hi_o = acc_q[W-1:0];
   assign prod_lo_o = lo_q;
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] prod_hi_o,
   input logic [W-1:0] prod_lo_o
);
   localparam int KW = $clog2(W + 2);

   logic [KW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R3
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_cnt == KW'(W))); // R3
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R4
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable({prod_hi_o, prod_lo_o})); // R6
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_booth_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .prod_hi_o (prod_hi_o),
   .prod_lo_o (prod_lo_o)
);

// File: tb/test_booth_seq_mul.sv
`timescale 1ns/1ps
module test_booth_seq_mul;
   localparam int N  = 5;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // narrow instance, exhaustive sweep
   logic          n_start = 1'b0;
   logic [N-1:0]  n_a = '0, n_b = '0;
   logic          n_busy, n_done;
   logic [N-1:0]  n_hi, n_lo;

   booth_seq_mul #(.W(N)) i_booth_seq_mul (
      .clk(clk), .rst_n(rst_n), .start_i(n_start),
      .mcand_i(n_a), .mplier_i(n_b),
      .busy_o(n_busy), .done_o(n_done),
      .prod_hi_o(n_hi), .prod_lo_o(n_lo)
   );

   // wide instance, directed corners
   logic          w_start = 1'b0;
   logic [WW-1:0] w_a = '0, w_b = '0;
   logic          w_busy, w_done;
   logic [WW-1:0] w_hi, w_lo;

   booth_seq_mul #(.W(WW)) i_booth_seq_mul_w (
      .clk(clk), .rst_n(rst_n), .start_i(w_start),
      .mcand_i(w_a), .mplier_i(w_b),
      .busy_o(w_busy), .done_o(w_done),
      .prod_hi_o(w_hi), .prod_lo_o(w_lo)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic run_n(input int a, input int b);
      int lat;
      int exp, act;
      @(negedge clk);
      n_a = N'(a); n_b = N'(b); n_start = 1'b1;
      @(negedge clk);
      n_start = 1'b0;
      lat = 0;
      while (!n_done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      exp = a * b;
      act = int'($signed({n_hi, n_lo}));
      chk(act == exp, "R2", $sformatf("narrow %0d*%0d", a, b), act, exp);
      chk(lat == N, "R3", "narrow latency", lat, N);
   endtask

   task automatic run_w(input logic [WW-1:0] a, input logic [WW-1:0] b,
                        input string req, input bit mid_start);
      int lat;
      longint exp, act;
      @(negedge clk);
      w_a = a; w_b = b; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      chk(w_busy == 1'b1, "R4", "busy after accept", w_busy, 1);
      lat = 0;
      while (!w_done && lat < 200) begin
         @(negedge clk);
         lat++;
         if (mid_start && lat == 5) begin
            w_a = 32'h7; w_b = 32'h3; w_start = 1'b1;  // must be ignored, R4
         end else begin
            w_start = 1'b0;
         end
      end
      w_start = 1'b0;
      exp = longint'($signed(a)) * longint'($signed(b));
      act = $signed({w_hi, w_lo});
      chk(act == exp, req, $sformatf("wide %0d*%0d", $signed(a), $signed(b)), act, exp);
      chk(lat == WW, "R3", "wide latency", lat, WW);
      chk(w_busy == 1'b0, "R4", "busy low with done", w_busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
   end

   initial begin
      longint held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({n_busy, n_done, n_hi, n_lo} == '0, "R1", "narrow reset", {n_hi, n_lo}, 0);
      chk({w_busy, w_done} == 2'b00 && {w_hi, w_lo} == '0, "R1", "wide reset",
          longint'({w_hi, w_lo}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 exhaustive narrow sweep (includes R5/R7 corners at width N)
      for (int a = -(1 << (N-1)); a < (1 << (N-1)); a++)
         for (int b = -(1 << (N-1)); b < (1 << (N-1)); b++)
            run_n(a, b);

      // R5 extreme wide operands
      run_w(32'h8000_0000, 32'h8000_0000, "R5", 1'b0);
      run_w(32'h8000_0000, 32'hFFFF_FFFF, "R5", 1'b0);
      run_w(32'h7FFF_FFFF, 32'h8000_0000, "R5", 1'b0);
      run_w(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
      run_w(32'h5555_5555, 32'hAAAA_AAAA, "R2", 1'b0);
      run_w(32'h1234_5678, 32'hF0F0_0F0F, "R2", 1'b0);
      // R7 zero operands
      run_w(32'h0, 32'hDEAD_BEEF, "R7", 1'b0);
      run_w(32'h8765_4321, 32'h0, "R7", 1'b0);
      // R4 start while busy ignored
      run_w(32'hFFFF_FF9C, 32'h0001_86A0, "R4", 1'b1);

      // R6 hold while idle
      held = $signed({w_hi, w_lo});
      repeat (4) @(negedge clk);
      chk($signed({w_hi, w_lo}) == held, "R6", "idle hold", $signed({w_hi, w_lo}), held);
      chk(w_done == 1'b0, "R3", "done single pulse", w_done, 0);

      summary();
   end
endmodule